// File: doc/BRIEF.md
# Virtual-8086 Interrupt Entry Frame Builder

This block takes over when an interrupt or exception reaches a core that is running a virtual-8086 task. It receives the interrupted program's segment registers, stack pointer, flags and instruction pointer, together with the decoded gate that the interrupt vectors through and the privilege-0 stack pointer. It checks that the gate may be used to leave virtual-8086 mode. A legal gate starts a nine-word frame on the privilege-0 stack, written through a valid/ready push port. An illegal gate instead raises a general-protection fault, reports the target code selector as the error code and touches no state.

On acceptance the block copies the interrupted state into its architectural output registers. It keeps the original flags for the frame and presents live flags with the mode, trap and interrupt-enable bits cleared. The four data segment registers are nulled once their images are on the stack. After the last push it switches to privilege 0, loads the handler's CS:EIP and the new stack pointer, and pulses completion.

Top module: `v86_irq_frame_seq`

## Requirements
- R1: A start pulse with gate type 14 or 15, a non-conforming target and target DPL 0 is accepted, and `push_valid` is high in the cycle after that start.
- R2: A start pulse with any gate type other than 14 or 15 gives a one-cycle `gp_fault` pulse in the next cycle, with `gp_code` equal to `tgt_cs`, and no push.
- R3: A start pulse whose target is conforming, or whose target DPL is not 0, gives the same fault as R2, with `gp_code` equal to `tgt_cs` and no push.
- R4: Nine 32-bit words are pushed in this order: GS, FS, DS, ES, SS, ESP, the original EFLAGS, CS, EIP. Selectors are zero-extended to 32 bits.
- R5: The first push goes to `stk0_sp_in - 4`. Every later push goes 4 bytes below the previous one, so the last push goes to `stk0_sp_in - 36`.
- R6: While `push_valid` is high and `push_ready` is low, the push stays pending with unchanged address and data.
- R7: From the cycle after acceptance, `eflags_out` equals the incoming flags with bit 17 (VM), bit 9 (IF) and bit 8 (TF) cleared. The pushed flags word keeps the original bits.
- R8: `gs_out`, `fs_out`, `ds_out` and `es_out` show the interrupted selectors until the ES push is accepted, and read 0 from the cycle after that handshake.
- R9: In the cycle after the ninth handshake, `done` is high for exactly one cycle. `cs_out`/`eip_out` then hold the target, `esp_out` holds `stk0_sp_in - 36` and `cpl_out` is 0.
- R10: A faulting start leaves `eflags_out`, the segment outputs, `cs_out`, `eip_out`, `esp_out` and `cpl_out` unchanged.
- R11: A start pulse that arrives while a frame is being pushed is ignored. It raises no fault, and the frame in progress continues unchanged.
- R12: After reset, `push_valid`, `done` and `gp_fault` are 0, `cpl_out` is 3, `eflags_out` is 32'h2, and the other state outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Interrupt arrival in virtual-8086 mode |
| eflags_in | input | 32 | Current flags |
| esp_in | input | 32 | Interrupted stack pointer |
| eip_in | input | 32 | Interrupted instruction pointer |
| cs_in | input | 16 | Interrupted code segment |
| ss_in | input | 16 | Interrupted stack segment |
| ds_in | input | 16 | Interrupted DS |
| es_in | input | 16 | Interrupted ES |
| fs_in | input | 16 | Interrupted FS |
| gs_in | input | 16 | Interrupted GS |
| stk0_sp_in | input | 32 | Privilege-0 stack pointer |
| gate_type | input | 4 | Gate descriptor type |
| tgt_conforming | input | 1 | Target code segment is conforming |
| tgt_dpl | input | 2 | Target code segment DPL |
| tgt_cs | input | 16 | Handler code selector |
| tgt_eip | input | 32 | Handler entry offset |
| push_valid | output | 1 | Push request pending |
| push_ready | input | 1 | Push accepted this cycle when high |
| push_addr | output | 32 | Push address |
| push_data | output | 32 | Push data |
| gp_fault | output | 1 | General-protection fault pulse |
| gp_code | output | 16 | Fault error code |
| done | output | 1 | Frame complete pulse |
| eflags_out | output | 32 | Live flags |
| cs_out | output | 16 | Code segment |
| eip_out | output | 32 | Instruction pointer |
| esp_out | output | 32 | Stack pointer after entry |
| gs_out | output | 16 | GS |
| fs_out | output | 16 | FS |
| ds_out | output | 16 | DS |
| es_out | output | 16 | ES |
| cpl_out | output | 2 | Current privilege level |

## Verification
The assertions assume that `push_ready` may take any value in any cycle. They also assume that `start` can arrive at any moment, even while a frame is in progress, and that the stack pointer given with an accepted start does not wrap below zero. The bench drives a privilege-0 stack pointer well above 36, so the address sequence never wraps. It holds `push_ready` low for single cycles and issues a stray start in the middle of a frame, which covers the stall and busy cases that the assertions rely on.

// File: rtl/v86_irq_frame_seq.sv
module v86_irq_frame_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] eflags_in,
  input  logic [31:0] esp_in,
  input  logic [31:0] eip_in,
  input  logic [15:0] cs_in,
  input  logic [15:0] ss_in,
  input  logic [15:0] ds_in,
  input  logic [15:0] es_in,
  input  logic [15:0] fs_in,
  input  logic [15:0] gs_in,
  input  logic [31:0] stk0_sp_in,
  input  logic [3:0]  gate_type,
  input  logic        tgt_conforming,
  input  logic [1:0]  tgt_dpl,
  input  logic [15:0] tgt_cs,
  input  logic [31:0] tgt_eip,
  output logic        push_valid,
  input  logic        push_ready,
  output logic [31:0] push_addr,
  output logic [31:0] push_data,
  output logic        gp_fault,
  output logic [15:0] gp_code,
  output logic        done,
  output logic [31:0] eflags_out,
  output logic [15:0] cs_out,
  output logic [31:0] eip_out,
  output logic [31:0] esp_out,
  output logic [15:0] gs_out,
  output logic [15:0] fs_out,
  output logic [15:0] ds_out,
  output logic [15:0] es_out,
  output logic [1:0]  cpl_out
);
  localparam logic [31:0] FLAG_CLR  = 32'h0002_0300;
  localparam logic [3:0]  LAST_IDX  = 4'd8;
  localparam logic [3:0]  SEG_IDX   = 4'd3;
  localparam logic [31:0] WORD      = 32'd4;

  logic        busy_q;
  logic [3:0]  idx_q;
  logic [31:0] sp_q, flags_tmp, old_esp, t_eip;
  logic [15:0] old_ss, t_cs;

  wire gate_ok = (gate_type == 4'd14 || gate_type == 4'd15) && !tgt_conforming && tgt_dpl == 2'd0;
  wire idle_st = start && !busy_q;
  wire hs      = busy_q && push_ready;

  assign push_valid = busy_q;
  assign push_addr  = sp_q;

  always_comb begin
    case (idx_q)
      4'd0:    push_data = {16'h0, gs_out};
      4'd1:    push_data = {16'h0, fs_out};
      4'd2:    push_data = {16'h0, ds_out};
      4'd3:    push_data = {16'h0, es_out};
      4'd4:    push_data = {16'h0, old_ss};
      4'd5:    push_data = old_esp;
      4'd6:    push_data = flags_tmp;
      4'd7:    push_data = {16'h0, cs_out};
      default: push_data = eip_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;  idx_q <= '0;  sp_q <= '0;
      flags_tmp <= '0; old_esp <= '0; old_ss <= '0; t_cs <= '0; t_eip <= '0;
      gp_fault <= 1'b0; gp_code <= '0; done <= 1'b0;
      eflags_out <= 32'h2; cs_out <= '0; eip_out <= '0; esp_out <= '0;
      gs_out <= '0; fs_out <= '0; ds_out <= '0; es_out <= '0;
      cpl_out <= 2'd3;
    end else begin
      done     <= 1'b0;
      gp_fault <= 1'b0;
      if (idle_st && !gate_ok) begin
        gp_fault <= 1'b1;
        gp_code  <= tgt_cs;
      end
      if (idle_st && gate_ok) begin
        busy_q     <= 1'b1;
        idx_q      <= '0;
        sp_q       <= stk0_sp_in - WORD;
        flags_tmp  <= eflags_in;
        eflags_out <= eflags_in & ~FLAG_CLR;
        old_esp    <= esp_in;
        old_ss     <= ss_in;
        t_cs       <= tgt_cs;
        t_eip      <= tgt_eip;
        cs_out     <= cs_in;
        eip_out    <= eip_in;
        gs_out     <= gs_in;
        fs_out     <= fs_in;
        ds_out     <= ds_in;
        es_out     <= es_in;
      end
      if (hs) begin
        idx_q <= idx_q + 4'd1;
        sp_q  <= sp_q - WORD;
        if (idx_q == SEG_IDX) begin
          gs_out <= '0; fs_out <= '0; ds_out <= '0; es_out <= '0;
        end
        if (idx_q == LAST_IDX) begin
          busy_q  <= 1'b0;
          done    <= 1'b1;
          cs_out  <= t_cs;
          eip_out <= t_eip;
          esp_out <= sp_q;
          cpl_out <= 2'd0;
        end
      end
    end
  end
endmodule

// File: rtl/v86_irq_frame_seq_chk.sv
module v86_irq_frame_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        push_valid,
  input logic        push_ready,
  input logic [31:0] push_addr,
  input logic [31:0] push_data,
  input logic        gp_fault,
  input logic        done,
  input logic [1:0]  cpl_out,
  input logic [31:0] eflags_out
);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_addr) && $stable(push_data));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_ready |=> !push_valid || push_addr == $past(push_addr) - 32'd4);

  assert_fault_no_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> !push_valid);

  assert_fault_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |=> !gp_fault);

  assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> eflags_out[17] == 1'b0 && eflags_out[9] == 1'b0 && eflags_out[8] == 1'b0);

  assert_done_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cpl_out == 2'd0 && !push_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind v86_irq_frame_seq v86_irq_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
  .push_addr(push_addr), .push_data(push_data), .gp_fault(gp_fault), .done(done),
  .cpl_out(cpl_out), .eflags_out(eflags_out)
);

// File: tb/v86_irq_frame_seq_bench.sv
module v86_irq_frame_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, push_ready = 1'b0;
  logic [31:0] eflags_in = '0, esp_in = '0, eip_in = '0, stk0_sp_in = '0, tgt_eip = '0;
  logic [15:0] cs_in = '0, ss_in = '0, ds_in = '0, es_in = '0, fs_in = '0, gs_in = '0, tgt_cs = '0;
  logic [3:0]  gate_type = '0;
  logic        tgt_conforming = 1'b0;
  logic [1:0]  tgt_dpl = '0;
  logic        push_valid, gp_fault, done;
  logic [31:0] push_addr, push_data, eflags_out, eip_out, esp_out;
  logic [15:0] gp_code, cs_out, gs_out, fs_out, ds_out, es_out;
  logic [1:0]  cpl_out;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  v86_irq_frame_seq u_v86_irq_frame_seq (.*);

  // {type[3:0], conforming, dpl[1:0], expect_fault, stall}
  localparam logic [8:0] VEC [10] = '{
    {4'd14, 1'b0, 2'd0, 1'b0, 1'b0},
    {4'd15, 1'b0, 2'd0, 1'b0, 1'b1},
    {4'd6,  1'b0, 2'd0, 1'b1, 1'b0},
    {4'd7,  1'b0, 2'd0, 1'b1, 1'b0},
    {4'd12, 1'b0, 2'd0, 1'b1, 1'b0},
    {4'd14, 1'b1, 2'd0, 1'b1, 1'b0},
    {4'd15, 1'b0, 2'd3, 1'b1, 1'b0},
    {4'd14, 1'b0, 2'd1, 1'b1, 1'b0},
    {4'd15, 1'b1, 2'd0, 1'b1, 1'b0},
    {4'd15, 1'b0, 2'd0, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input int i, input logic [8:0] v);
    logic [31:0] exp_w [9];
    logic [31:0] sp0, fl, p_fl, p_eip, p_esp;
    logic [15:0] p_cs, p_gs;
    logic [1:0]  p_cpl;
    bit fault;
    fault = v[1];
    fl    = 32'h0002_0302 | (32'(i) << 12);
    sp0   = 32'h0000_8000 + 32'(i) * 32'h100;
    @(negedge clk);
    gs_in = 16'h1100 + 16'(i); fs_in = 16'h2200 + 16'(i);
    ds_in = 16'h3300 + 16'(i); es_in = 16'h4400 + 16'(i);
    ss_in = 16'h5500 + 16'(i); esp_in = 32'h0000_FFF0 - 32'(i);
    eflags_in = fl; cs_in = 16'h6600 + 16'(i); eip_in = 32'h0000_1230 + 32'(i);
    stk0_sp_in = sp0; gate_type = v[8:5]; tgt_conforming = v[4]; tgt_dpl = v[3:2];
    tgt_cs = 16'h0008 + 16'(i) * 16'h10; tgt_eip = 32'hC000_0000 + 32'(i);
    exp_w = '{{16'h0, gs_in}, {16'h0, fs_in}, {16'h0, ds_in}, {16'h0, es_in},
              {16'h0, ss_in}, esp_in, fl, {16'h0, cs_in}, eip_in};
    p_fl = eflags_out; p_eip = eip_out; p_esp = esp_out; p_cs = cs_out; p_gs = gs_out; p_cpl = cpl_out;
    start = 1'b1; push_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (fault) begin
      chk(gp_fault && !push_valid, "R2/R3 fault pulse", {31'h0, gp_fault}, 32'h1);
      chk(gp_code == tgt_cs, "R2/R3 error code", {16'h0, gp_code}, {16'h0, tgt_cs});
      chk(eflags_out == p_fl && eip_out == p_eip && esp_out == p_esp && cs_out == p_cs &&
          gs_out == p_gs && cpl_out == p_cpl, "R10 state kept", eflags_out, p_fl);
      @(negedge clk);
      chk(!gp_fault && !push_valid, "R2 single pulse", {31'h0, gp_fault}, 32'h0);
    end else begin
      chk(push_valid, "R1 accept", {31'h0, push_valid}, 32'h1);
      chk(eflags_out == (fl & ~32'h0002_0300), "R7 live flags", eflags_out, fl & ~32'h0002_0300);
      for (int k = 0; k < 9; k++) begin
        if (v[0]) begin
          push_ready = 1'b0;
          @(negedge clk);
          chk(push_valid && push_addr == sp0 - 32'(4 * (k + 1)), "R6 stall hold", push_addr, sp0 - 32'(4 * (k + 1)));
          push_ready = 1'b1;
        end
        chk(push_addr == sp0 - 32'(4 * (k + 1)), "R5 address", push_addr, sp0 - 32'(4 * (k + 1)));
        chk(push_data == exp_w[k], "R4 push data", push_data, exp_w[k]);
        if (k == 3) chk(ds_out == ds_in && gs_out == gs_in, "R8 segs before ES", {16'h0, ds_out}, {16'h0, ds_in});
        if (k == 4) chk(gs_out == 0 && fs_out == 0 && ds_out == 0 && es_out == 0, "R8 segs nulled", {16'h0, gs_out}, 32'h0);
        if (k == 5 && i == 1) begin
          gate_type = 4'd6; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        if (k == 5 && i == 1) chk(!gp_fault && push_addr == sp0 - 32'd28, "R11 start ignored", push_addr, sp0 - 32'd28);
      end
      chk(done && !push_valid, "R9 done", {31'h0, done}, 32'h1);
      chk(cs_out == tgt_cs && eip_out == tgt_eip, "R9 target loaded", eip_out, tgt_eip);
      chk(esp_out == sp0 - 32'd36 && cpl_out == 2'd0, "R9 new stack", esp_out, sp0 - 32'd36);
      @(negedge clk);
      chk(!done, "R9 done pulse", {31'h0, done}, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!push_valid && !done && !gp_fault, "R12 reset outputs", {29'h0, push_valid, done, gp_fault}, 32'h0);
    chk(cpl_out == 2'd3 && eflags_out == 32'h2, "R12 reset state", eflags_out, 32'h2);
    chk(cs_out == 0 && eip_out == 0 && esp_out == 0 && gs_out == 0, "R12 reset zeros", eip_out, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) run_case(i, VEC[i]);
    // corner: fault right after a completed frame keeps the handler state (R10)
    run_case(10, {4'd15, 1'b0, 2'd2, 1'b1, 1'b0});
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule